// File: doc/BRIEF.md
# Hall-Sensor Commutation Output Controller

This block turns three rotor-position levels into the six gate-drive signals of a three-phase bridge, one high-side and one low-side signal per phase. The position code comes either from three external sensor pins, which pass through a synchronizer and an optional majority-free run-length noise filter, or from three software-set bits. A sector decoder picks one high-side phase and one low-side phase for each valid code. The output stage then applies per-side chopping by an externally generated PWM carrier, output polarity and the drive enable.

Software sets the configuration through plain level inputs and an enable register. The enable can be written, and a group-disable event can clear it when that function is armed. An alignment option holds a new position code back until the carrier's next falling edge, so a commutation never lands in the middle of a carrier pulse. The filtered external levels are always visible on a monitor output.

Top module: `hall_commutator`

## Requirements
- R1: `drive_oe` equals the value `en_status` had one clock earlier. While `drive_oe` is 0, all six outputs sit at the inactive level (0 when `cfg_invert` is 0, 1 when it is 1).
- R2: `en_status` resets to 0. A cycle with `cfg_en_wr`=1 loads `cfg_en_wdata` into `en_status` at that clock edge.
- R3: With `cfg_grp_func`=1, a cycle with `grp_off`=1 clears `en_status` at that edge, and this takes priority over a write in the same cycle. With `cfg_grp_func`=0, `grp_off` has no effect.
- R4: `cfg_src_soft`=1 selects `cfg_soft_code` as the position code. `cfg_src_soft`=0 selects the filtered external pins. A soft code reaches the outputs two edges after it is applied.
- R5: Code bit order is {U,V,W} = [2:0], and the same order is used for `hi_out` and `lo_out`. In forward direction the active (high-side, low-side) phases are: 101→(U,V), 100→(U,W), 110→(V,W), 010→(V,U), 011→(W,U), 001→(W,V). Codes 000 and 111 leave every output inactive.
- R6: `cfg_reverse`=1 swaps the high-side and low-side phase sets of R5.
- R7: When `cfg_hi_pwm`=1, an active high-side output follows the carrier sampled at the previous edge; when it is 0, the output holds a steady active level. `cfg_lo_pwm` does the same for the low side.
- R8: `cfg_invert`=1 inverts all six outputs, so an active output reads 0 and an inactive one reads 1.
- R9: With `cfg_align`=1, the position code in use changes only at the edge following a carrier fall (1 then 0). With `cfg_align`=0, it follows the selected source every cycle.
- R10: With `cfg_filt_en`=1, an external level is accepted only after three consecutive equal samples. Samples are taken every 1, 4, 16 or 64 clocks for `cfg_filt_div` = 00, 01, 10, 11. With `cfg_filt_en`=0, the synchronized level passes straight through (three edges from pin to monitor).
- R11: `hall_mon` shows the synchronized, filtered external levels, whichever source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_pin | input | 3 | External position sensor levels {U,V,W} |
| carrier | input | 1 | PWM carrier from an external timer |
| grp_off | input | 1 | Group-disable event |
| cfg_en_wr | input | 1 | Write strobe for the enable register |
| cfg_en_wdata | input | 1 | Value written to the enable register |
| cfg_grp_func | input | 1 | Arms the group disable to clear the enable |
| cfg_src_soft | input | 1 | 1 selects software code, 0 selects pins |
| cfg_soft_code | input | 3 | Software position code {U,V,W} |
| cfg_hi_pwm | input | 1 | High side chopped by carrier when 1 |
| cfg_lo_pwm | input | 1 | Low side chopped by carrier when 1 |
| cfg_invert | input | 1 | Active-low outputs when 1 |
| cfg_reverse | input | 1 | Reverse commutation when 1 |
| cfg_align | input | 1 | Apply new code only on carrier fall when 1 |
| cfg_filt_en | input | 1 | Enables the external input filter |
| cfg_filt_div | input | 2 | Filter sample-rate select |
| en_status | output | 1 | Current enable register value |
| hall_mon | output | 3 | Filtered external levels {U,V,W} |
| drive_oe | output | 1 | Output-drive enable (0 = high impedance) |
| hi_out | output | 3 | High-side gate signals {U,V,W} |
| lo_out | output | 3 | Low-side gate signals {U,V,W} |

## Verification
The bench sweeps every code under every combination of direction, polarity, per-side mode and carrier level. A decoder with a rotated phase table, a missing swap or a wrong side gating therefore shows up as a wrong bit on one of the six outputs. It exercises the enable priority by raising an armed group disable together with a write: a design that lets the write win keeps driving. For alignment, it changes the code while the carrier is high and checks the exact edge at which the outputs move after the fall. A design that applies codes early or on the rise moves too soon. For the filter, it applies glitches shorter than three sample periods at several rates and times acceptance windows; a wrong divider or a two-sample filter passes the glitch or accepts too early.

// File: rtl/hall_pkg.sv
package hall_pkg;
   localparam int HALL_PHASES = 3;

   typedef logic [HALL_PHASES-1:0] phase_t;

   // Successor in the forward rotation U(2) -> V(1) -> W(0) -> U(2)
   function automatic int next_phase(input int p);
      return (p + HALL_PHASES - 1) % HALL_PHASES;
   endfunction
endpackage

// File: rtl/hall_in_filter.sv
module hall_in_filter
   import hall_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int FILT_DEPTH    = 3,
   parameter int DIV_STEP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  phase_t     pin,
   input  logic       filt_en,
   input  logic [1:0] div_sel,
   output phase_t     level
);
   localparam int PRE_W  = DIV_STEP_LOG2 * 3;
   localparam int HIST_W = FILT_DEPTH - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hall_in_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_DEPTH < 2) begin : g_bad_depth
      $error("hall_in_filter: FILT_DEPTH must be at least 2");
   end

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] pre_mask;
   logic             tick;

   always_comb begin
      pre_mask = PRE_W'((1 << (DIV_STEP_LOG2 * int'(div_sel))) - 1);
      tick     = ((pre_cnt & pre_mask) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
   end

   for (genvar p = 0; p < HALL_PHASES; p++) begin : g_ph
      logic [SYNC_STAGES-1:0] chain;
      logic [HIST_W-1:0]      hist;
      logic                   smp;
      logic                   agree;
      logic                   lvl;

      assign smp   = chain[SYNC_STAGES-1];
      assign agree = (hist == {HIST_W{smp}});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            hist  <= '0;
            lvl   <= 1'b0;
         end else begin
            chain <= {chain[SYNC_STAGES-2:0], pin[p]};
            if (tick) hist <= HIST_W'({hist, smp});
            if (!filt_en)           lvl <= smp;
            else if (tick && agree) lvl <= smp;
         end
      end

      assign level[p] = lvl;
   end
endmodule

// File: rtl/hall_sector_decode.sv
module hall_sector_decode
   import hall_pkg::*;
(
   input  phase_t code,
   input  logic   reverse,
   output phase_t sel_hi,
   output phase_t sel_lo
);
   phase_t fwd_hi;
   phase_t fwd_lo;

   // A phase leads high when it is set and its successor is clear;
   // it is the low phase when it is clear and its successor is set.
   for (genvar p = 0; p < HALL_PHASES; p++) begin : g_sec
      localparam int NX = next_phase(p);
      assign fwd_hi[p] =  code[p] & ~code[NX];
      assign fwd_lo[p] = ~code[p] &  code[NX];
   end

   assign sel_hi = reverse ? fwd_lo : fwd_hi;
   assign sel_lo = reverse ? fwd_hi : fwd_lo;
endmodule

// File: rtl/hall_drive.sv
module hall_drive
   import hall_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   enable,
   input  logic   carrier,
   input  phase_t sel_hi,
   input  phase_t sel_lo,
   input  logic   hi_pwm,
   input  logic   lo_pwm,
   input  logic   invert,
   output logic   oe,
   output phase_t hi_out,
   output phase_t lo_out
);
   localparam int SIDES = 2;

   phase_t sel   [SIDES];
   logic   pwm   [SIDES];
   phase_t drv_q [SIDES];

   assign sel[0] = sel_hi;
   assign sel[1] = sel_lo;
   assign pwm[0] = hi_pwm;
   assign pwm[1] = lo_pwm;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      logic   gate;
      phase_t act;

      assign gate = pwm[s] ? carrier : 1'b1;
      assign act  = sel[s] & {HALL_PHASES{enable & gate}};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q[s] <= '0;
         else        drv_q[s] <= act ^ {HALL_PHASES{invert}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe <= 1'b0;
      else        oe <= enable;
   end

   assign hi_out = drv_q[0];
   assign lo_out = drv_q[1];
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
   import hall_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int FILT_DEPTH    = 3,
   parameter int DIV_STEP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_pin,
   input  logic       carrier,
   input  logic       grp_off,
   input  logic       cfg_en_wr,
   input  logic       cfg_en_wdata,
   input  logic       cfg_grp_func,
   input  logic       cfg_src_soft,
   input  logic [2:0] cfg_soft_code,
   input  logic       cfg_hi_pwm,
   input  logic       cfg_lo_pwm,
   input  logic       cfg_invert,
   input  logic       cfg_reverse,
   input  logic       cfg_align,
   input  logic       cfg_filt_en,
   input  logic [1:0] cfg_filt_div,
   output logic       en_status,
   output logic [2:0] hall_mon,
   output logic       drive_oe,
   output logic [2:0] hi_out,
   output logic [2:0] lo_out
);
   phase_t filt_lvl;
   phase_t src_code;
   phase_t cur_code;
   phase_t sel_hi;
   phase_t sel_lo;
   logic   en_q;
   logic   car_q;
   logic   car_fall;

   hall_in_filter #(
      .SYNC_STAGES   (SYNC_STAGES),
      .FILT_DEPTH    (FILT_DEPTH),
      .DIV_STEP_LOG2 (DIV_STEP_LOG2)
   ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (hall_pin),
      .filt_en (cfg_filt_en),
      .div_sel (cfg_filt_div),
      .level   (filt_lvl)
   );

   // Enable register: armed group disable beats a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        en_q <= 1'b0;
      else if (grp_off && cfg_grp_func)  en_q <= 1'b0;
      else if (cfg_en_wr)                en_q <= cfg_en_wdata;
   end

   assign src_code = cfg_src_soft ? cfg_soft_code : filt_lvl;
   assign car_fall = car_q & ~carrier;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_q    <= 1'b0;
         cur_code <= '0;
      end else begin
         car_q <= carrier;
         if (!cfg_align || car_fall) cur_code <= src_code;
      end
   end

   hall_sector_decode u_dec (
      .code    (cur_code),
      .reverse (cfg_reverse),
      .sel_hi  (sel_hi),
      .sel_lo  (sel_lo)
   );

   hall_drive u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (en_q),
      .carrier (carrier),
      .sel_hi  (sel_hi),
      .sel_lo  (sel_lo),
      .hi_pwm  (cfg_hi_pwm),
      .lo_pwm  (cfg_lo_pwm),
      .invert  (cfg_invert),
      .oe      (drive_oe),
      .hi_out  (hi_out),
      .lo_out  (lo_out)
   );

   assign en_status = en_q;
   assign hall_mon  = filt_lvl;
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       grp_off,
   input logic       cfg_grp_func,
   input logic       cfg_en_wr,
   input logic       cfg_en_wdata,
   input logic       cfg_invert,
   input logic       en_status,
   input logic       drive_oe,
   input logic [2:0] hi_out,
   input logic [2:0] lo_out
);
   assert_oe_tracks_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drive_oe == $past(en_status)));

   assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_oe |-> ((hi_out == lo_out) && ((hi_out == 3'b000) || (hi_out == 3'b111))));

   assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en_wr && !(grp_off && cfg_grp_func)) |=> (en_status == $past(cfg_en_wdata)));

   assert_grp_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_off && cfg_grp_func) |=> !en_status);

   assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en_wr && !(grp_off && cfg_grp_func)) |=> $stable(en_status));

   assert_no_shoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_oe |-> (((hi_out ^ {3{$past(cfg_invert)}}) & (lo_out ^ {3{$past(cfg_invert)}})) == 3'b000));

   assert_single_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_oe |-> ($onehot0(hi_out ^ {3{$past(cfg_invert)}}) && $onehot0(lo_out ^ {3{$past(cfg_invert)}})));
endmodule

bind hall_commutator hall_commutator_chk u_chk (.*);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_pin = '0;
   logic       carrier = 1'b1;
   logic       grp_off = 1'b0;
   logic       cfg_en_wr = 1'b0;
   logic       cfg_en_wdata = 1'b0;
   logic       cfg_grp_func = 1'b0;
   logic       cfg_src_soft = 1'b1;
   logic [2:0] cfg_soft_code = '0;
   logic       cfg_hi_pwm = 1'b0;
   logic       cfg_lo_pwm = 1'b0;
   logic       cfg_invert = 1'b0;
   logic       cfg_reverse = 1'b0;
   logic       cfg_align = 1'b0;
   logic       cfg_filt_en = 1'b0;
   logic [1:0] cfg_filt_div = 2'b00;
   logic       en_status;
   logic [2:0] hall_mon;
   logic       drive_oe;
   logic [2:0] hi_out;
   logic [2:0] lo_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hall_commutator dut_i (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Forward-direction phase table from the requirements, {U,V,W}
   function automatic logic [2:0] tab_hi(input logic [2:0] c);
      case (c)
         3'b101, 3'b100: return 3'b100;
         3'b110, 3'b010: return 3'b010;
         3'b011, 3'b001: return 3'b001;
         default:        return 3'b000;
      endcase
   endfunction

   function automatic logic [2:0] tab_lo(input logic [2:0] c);
      case (c)
         3'b101, 3'b001: return 3'b010;
         3'b100, 3'b110: return 3'b001;
         3'b010, 3'b011: return 3'b100;
         default:        return 3'b000;
      endcase
   endfunction

   function automatic logic [5:0] expect_out(input logic [2:0] c, input logic rev,
      input logic inv, input logic hp, input logic lp, input logic car);
      logic [2:0] h, l;
      h = rev ? tab_lo(c) : tab_hi(c);
      l = rev ? tab_hi(c) : tab_lo(c);
      h = h & {3{hp ? car : 1'b1}};
      l = l & {3{lp ? car : 1'b1}};
      return {h ^ {3{inv}}, l ^ {3{inv}}};
   endfunction

   initial begin
      step(3);
      check("R2 reset en_status", en_status, 0);
      check("R1 reset drive_oe", drive_oe, 0);
      check("R1 reset outputs", {hi_out, lo_out}, 6'b0);
      rst_n = 1'b1;
      step(2);

      // Enable write
      cfg_en_wr = 1'b1; cfg_en_wdata = 1'b1;
      step(1);
      cfg_en_wr = 1'b0;
      check("R2 write enable", en_status, 1);
      check("R1 oe one cycle later", drive_oe, 0);
      step(1);
      check("R1 oe follows enable", drive_oe, 1);

      // Sweep: every code x direction x polarity x side modes x carrier
      for (int i = 0; i < 256; i++) begin
         cfg_soft_code = i[2:0];
         cfg_reverse   = i[3];
         cfg_invert    = i[4];
         cfg_hi_pwm    = i[5];
         cfg_lo_pwm    = i[6];
         carrier       = i[7];
         step(2);
         check("R5 R6 R7 R8 R4 hi side", hi_out,
               expect_out(i[2:0], i[3], i[4], i[5], i[6], i[7]) >> 3);
         check("R5 R6 R7 R8 R4 lo side", lo_out,
               expect_out(i[2:0], i[3], i[4], i[5], i[6], i[7]) & 6'h7);
      end

      // Disabled outputs sit at the inactive level
      cfg_hi_pwm = 1'b0; cfg_lo_pwm = 1'b0; cfg_reverse = 1'b0; carrier = 1'b1;
      cfg_invert = 1'b1; cfg_soft_code = 3'b101;
      cfg_en_wr = 1'b1; cfg_en_wdata = 1'b0;
      step(1);
      cfg_en_wr = 1'b0;
      step(2);
      check("R1 disabled oe", drive_oe, 0);
      check("R1 disabled inactive high", {hi_out, lo_out}, 6'b111111);
      cfg_invert = 1'b0;
      step(2);
      check("R1 disabled inactive low", {hi_out, lo_out}, 6'b000000);
      cfg_en_wr = 1'b1; cfg_en_wdata = 1'b1;
      step(1);
      cfg_en_wr = 1'b0;

      // Group disable ignored when not armed
      cfg_grp_func = 1'b0; grp_off = 1'b1;
      step(3);
      check("R3 unarmed grp ignored", en_status, 1);
      step(1);
      check("R3 unarmed outputs driven", {drive_oe, hi_out, lo_out}, {1'b1, 3'b100, 3'b010});
      // Armed: beats a same-cycle write
      cfg_grp_func = 1'b1; cfg_en_wr = 1'b1; cfg_en_wdata = 1'b1;
      step(1);
      cfg_en_wr = 1'b0; grp_off = 1'b0;
      check("R3 armed grp clears over write", en_status, 0);
      step(1);
      check("R3 armed grp oe off", drive_oe, 0);
      cfg_en_wr = 1'b1; cfg_en_wdata = 1'b1;
      step(1);
      cfg_en_wr = 1'b0;
      check("R3 re-enable after grp", en_status, 1);

      // External source, filter off
      cfg_src_soft = 1'b0; cfg_filt_en = 1'b0; hall_pin = 3'b110; cfg_soft_code = 3'b001;
      step(8);
      check("R4 external source hi", hi_out, 3'b010);
      check("R4 external source lo", lo_out, 3'b001);
      check("R11 monitor external", hall_mon, 3'b110);
      cfg_src_soft = 1'b1;
      step(3);
      check("R4 soft source hi", hi_out, 3'b001);
      check("R11 monitor with soft source", hall_mon, 3'b110);

      // Alignment to carrier fall
      cfg_soft_code = 3'b101; carrier = 1'b1;
      step(3);
      cfg_align = 1'b1; cfg_soft_code = 3'b011;
      step(6);
      check("R9 held while carrier high", {hi_out, lo_out}, {3'b100, 3'b010});
      carrier = 1'b0;
      step(1);
      check("R9 not yet at output", {hi_out, lo_out}, {3'b100, 3'b010});
      step(1);
      check("R9 applied after fall", {hi_out, lo_out}, {3'b001, 3'b100});
      cfg_soft_code = 3'b110;
      step(4);
      check("R9 no update while low", {hi_out, lo_out}, {3'b001, 3'b100});
      carrier = 1'b1;
      step(4);
      check("R9 no update on rise", {hi_out, lo_out}, {3'b001, 3'b100});
      cfg_align = 1'b0;
      step(2);
      check("R9 align off follows", {hi_out, lo_out}, {3'b010, 3'b001});

      // Noise filter
      hall_pin = 3'b000; cfg_filt_en = 1'b0;
      step(5);
      check("R10 bypass settle", hall_mon, 3'b000);
      cfg_filt_en = 1'b1; cfg_filt_div = 2'b01;
      hall_pin = 3'b111; step(6); hall_pin = 3'b000;
      step(20);
      check("R10 div4 glitch rejected", hall_mon, 3'b000);
      hall_pin = 3'b111;
      step(6);
      check("R10 div4 not early", hall_mon, 3'b000);
      step(14);
      check("R10 div4 accepted", hall_mon, 3'b111);
      cfg_filt_div = 2'b11; hall_pin = 3'b000;
      step(100);
      check("R10 div64 not early", hall_mon, 3'b111);
      step(150);
      check("R10 div64 accepted", hall_mon, 3'b000);
      cfg_filt_div = 2'b00;
      hall_pin = 3'b111; step(2); hall_pin = 3'b000;
      step(10);
      check("R10 div1 glitch rejected", hall_mon, 3'b000);
      hall_pin = 3'b101;
      step(8);
      check("R10 div1 accepted", hall_mon, 3'b101);
      cfg_filt_div = 2'b10; hall_pin = 3'b010;
      step(25);
      check("R10 div16 not early", hall_mon, 3'b101);
      step(60);
      check("R10 div16 accepted", hall_mon, 3'b010);
      cfg_filt_en = 1'b0; hall_pin = 3'b011;
      step(3);
      check("R10 bypass three edges", hall_mon, 3'b011);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule